// File: doc/BRIEF.md
# Strap-Configured Bus Mode Register

This block is a 16-bit control register on a simple peripheral bus. It decides how a shared external parallel port and two serial pin groups are routed. It also controls the clock output, the oscillator stop and the pin keepers.

The parallel port mode field takes its reset value from a strap input. The strap is sampled during a synchronous active-low reset, and once reset has been released it has no further effect. Values 10 and 11 of that field both mean host port mode.

A separate idle gate decides whether an idle request may stop the clock domain. Outside host port mode, any idle request is granted. In host port mode, a request is granted only when the register's host-idle bit is 1 and the external idle-control flag is already high in the same cycle as the request. This rule keeps host access alive unless software has opted in.

Top module: `busmode_ctrl_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register loads 0x0201 if `strap_mode` is 1 and 0x0203 if it is 0. All bits are 0 except bit 9 (1) and bits 1:0 (01 or 11).
- R2: A write with `bus_we` = 1 at address 0x6C00 loads all 16 bits of `bus_wdata` into the register at that clock edge. A read at 0x6C00 returns the full register value on `bus_rdata`.
- R3: A write to any other address leaves the register unchanged, and a read at any other address returns 0.
- R4: The select outputs change in the cycle after the write, not in the write cycle. `par_mode_sel` carries bits 1:0, `sp1_sel` carries bits 3:2 and `sp2_sel` carries bits 5:4.
- R5: `host_mode` is 1 exactly when bit 1 of the register is 1, that is, when the parallel mode is 10 or 11.
- R6: In host port mode with bit 13 at 0, `idle_ok` is never 1, whatever the values of `idle_req` and `idle_ctl`.
- R7: In host port mode with bit 13 at 1, `idle_ok` equals `idle_req` AND `idle_ctl`, both sampled in the same cycle.
- R8: Outside host port mode, `idle_ok` equals `idle_req`.
- R9: `clkout_en` is the inverse of bit 15, and `keeper_en` is the inverse of bit 12.
- R10: `osc_stop` is 1 exactly when `idle_ok` is 1 and bit 14 is 1.
- R11: Changing `strap_mode` while `rst_n` is high has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_mode | input | 1 | Mode strap, sampled during reset |
| bus_addr | input | 16 | Access address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data; 0 when the address does not match |
| par_mode_sel | output | 2 | Parallel port routing select |
| sp1_sel | output | 2 | Serial group 1 routing select |
| sp2_sel | output | 2 | Serial group 2 routing select |
| host_mode | output | 1 | Parallel port is in host port mode |
| clkout_en | output | 1 | Clock output enable |
| keeper_en | output | 1 | Keepers and pull resistors enabled |
| idle_req | input | 1 | Idle request |
| idle_ctl | input | 1 | External idle-control flag |
| idle_ok | output | 1 | Idle is permitted |
| osc_stop | output | 1 | Stop the oscillator |

## Verification
A register write and an idle request can fall in the same cycle. When they do, the idle decision must still use the register contents from before the write.

The bench provokes this by writing in one cycle a value that moves the port into or out of host mode, or that flips the host-idle bit, while `idle_req` and `idle_ctl` are high. It then checks `idle_ok` and `osc_stop` in that cycle against the old contents and in the next cycle against the new ones. A behavioural model updated at each rising edge supplies the expected values for every output, sampled at the falling edge.

// File: rtl/busmode_ctrl_reg.sv
module busmode_ctrl_reg #(
  parameter int          AW       = 16,
  parameter logic [15:0] REG_ADDR = 16'h6C00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_mode,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic [1:0]    par_mode_sel,
  output logic [1:0]    sp1_sel,
  output logic [1:0]    sp2_sel,
  output logic          host_mode,
  output logic          clkout_en,
  output logic          keeper_en,
  input  logic          idle_req,
  input  logic          idle_ctl,
  output logic          idle_ok,
  output logic          osc_stop
);
  localparam int B_CLKOFF = 15;
  localparam int B_OSCOFF = 14;
  localparam int B_HIDLE  = 13;
  localparam int B_KEEPOF = 12;
  localparam int B_HOLDA  = 9;
  localparam logic [AW-1:0] HIT = AW'(REG_ADDR);

  logic [15:0] cfg_q;
  logic        hit, wr_hit;

  assign hit    = (bus_addr == HIT);
  assign wr_hit = hit & bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q          <= '0;
      cfg_q[B_HOLDA] <= 1'b1;
      cfg_q[1:0]     <= strap_mode ? 2'b01 : 2'b11;
    end else if (wr_hit) begin
      cfg_q <= bus_wdata;
    end
  end

  assign bus_rdata    = hit ? cfg_q : 16'h0000;
  assign par_mode_sel = cfg_q[1:0];
  assign sp1_sel      = cfg_q[3:2];
  assign sp2_sel      = cfg_q[5:4];
  assign host_mode    = cfg_q[1];
  assign clkout_en    = ~cfg_q[B_CLKOFF];
  assign keeper_en    = ~cfg_q[B_KEEPOF];
  assign idle_ok      = idle_req & (~host_mode | (cfg_q[B_HIDLE] & idle_ctl));
  assign osc_stop     = idle_ok & cfg_q[B_OSCOFF];

  // R1
  rst_value_chk: assert property (@(posedge clk)
    !rst_n |=> (cfg_q[15:2] == 14'h0080) && cfg_q[0]);

  // R4
  sel_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (par_mode_sel == $past(bus_wdata[1:0])) && (sp1_sel == $past(bus_wdata[3:2]))
               && (sp2_sel == $past(bus_wdata[5:4])));

  // R3
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(cfg_q));

  // R6
  host_idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode_sel[1] && !cfg_q[B_HIDLE]) |-> !idle_ok);

  // R10
  osc_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> idle_ok && idle_req);
endmodule

// File: tb/busmode_ctrl_reg_bench.sv
module busmode_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_mode = 1'b1;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic        idle_req = 1'b0;
  logic        idle_ctl = 1'b0;
  logic [15:0] bus_rdata;
  logic [1:0]  par_mode_sel, sp1_sel, sp2_sel;
  logic        host_mode, clkout_en, keeper_en, idle_ok, osc_stop;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] mdl;
  bit mdl_valid = 0;

  always #10 clk = ~clk;

  busmode_ctrl_reg u_busmode_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .par_mode_sel(par_mode_sel), .sp1_sel(sp1_sel), .sp2_sel(sp2_sel),
    .host_mode(host_mode), .clkout_en(clkout_en), .keeper_en(keeper_en),
    .idle_req(idle_req), .idle_ctl(idle_ctl), .idle_ok(idle_ok), .osc_stop(osc_stop)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mdl = strap_mode ? 16'h0201 : 16'h0203;
      mdl_valid = 1;
    end else if (bus_we && bus_addr == 16'h6C00) begin
      mdl = bus_wdata;
    end
  end

  always @(negedge clk) begin
    if (mdl_valid && !done) begin
      bit hm;
      bit ok;
      hm = mdl[1];
      ok = idle_req && (!hm || (mdl[13] && idle_ctl));
      check("R1/R2/R3 rdata", bus_rdata, (bus_addr == 16'h6C00) ? mdl : 16'h0);
      check("R4 par_mode_sel", par_mode_sel, mdl[1:0]);
      check("R4 sp1_sel", sp1_sel, mdl[3:2]);
      check("R4 sp2_sel", sp2_sel, mdl[5:4]);
      check("R5 host_mode", host_mode, hm);
      check("R6/R7/R8 idle_ok", idle_ok, ok);
      check("R9 clkout_en", clkout_en, !mdl[15]);
      check("R9 keeper_en", keeper_en, !mdl[12]);
      check("R10 osc_stop", osc_stop, ok && mdl[14]);
    end
  end

  task automatic step(input logic [15:0] a, input logic we, input logic [15:0] d,
                      input logic rq, input logic ct);
    @(posedge clk); #2;
    bus_addr = a; bus_we = we; bus_wdata = d; idle_req = rq; idle_ctl = ct;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    bus_addr = 16'h6C00;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R11: strap moves after reset
    step(16'h6C00, 0, 0, 0, 0); strap_mode = 0;
    step(16'h6C00, 0, 0, 1, 1);
    // R2/R4: full write then readback
    step(16'h6C00, 1, 16'hF03C, 0, 0);
    step(16'h6C00, 0, 0, 0, 0);
    // R3: write elsewhere, read elsewhere
    step(16'h6C01, 1, 16'hFFFF, 0, 0);
    step(16'h1234, 0, 0, 0, 0);
    step(16'h6C00, 0, 0, 0, 0);
    // R6: host mode, host idle off
    step(16'h6C00, 1, 16'h4003, 0, 0);
    for (int i = 0; i < 4; i++) step(16'h6C00, 0, 0, i[0], i[1]);
    // R7/R10: host mode, host idle on, mode 10
    step(16'h6C00, 1, 16'h6002, 0, 0);
    for (int i = 0; i < 4; i++) step(16'h6C00, 0, 0, i[0], i[1]);
    // write and idle request in the same cycle
    step(16'h6C00, 1, 16'h4001, 1, 1);
    step(16'h6C00, 0, 0, 1, 0);
    step(16'h6C00, 1, 16'h4002, 1, 0);
    step(16'h6C00, 0, 0, 1, 0);
    // R8: non-host, mode 00
    step(16'h6C00, 1, 16'h9000, 0, 0);
    for (int i = 0; i < 4; i++) step(16'h6C00, 0, 0, i[0], i[1]);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = ($urandom % 2) ? 16'h6C00 : 16'($urandom);
      step(a, 1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
    end
    // R1: reset with strap low
    step(16'h6C00, 0, 0, 0, 0); rst_n = 0;
    step(16'h6C00, 0, 0, 0, 0); rst_n = 1;
    step(16'h6C00, 0, 0, 1, 0);
    step(16'h6C00, 0, 0, 0, 0);
    finish_run();
  end
endmodule